// File: doc/BRIEF.md
# In-Order Memory Response Retirement Buffer

This block sits between the instruction side of a vector compute unit and its global-memory path. It follows each memory request from the moment it is queued, through its dispatch to the memory system, to the point where its result is handed to the register file. Incoming requests wait in a short issue queue, and each one receives a sequence tag when it enters. The queue head moves downstream over a valid/ready handshake, but only while its traffic class has a free in-flight slot. Loads and atomics share one cap. Stores have a separate cap of the same size. Memory syncs are bound by neither cap.

Every dispatched request takes a slot in a tag-ordered tracking buffer. The slot is a circular array addressed by the low tag bits. Completion responses can come back in any order, and each one marks its slot done. Retirement is strictly oldest-first. Only the oldest slot can retire, and only after it is done. Results that write registers (loads and atomics) also need the register-file write port and the return bus to be free. A retirement releases the slot and the in-flight credit of its class.

A response that names a tag with no live slot is flagged on an error output in the same cycle. The memory system, the register file and address translation lie outside this block.

Top module: `mem_retire_buf`

## Requirements
- R1: The issue queue holds up to IQ_DEPTH requests. `req_ready` is low exactly when it is full, and a request offered while `req_ready` is low is dropped and consumes no tag.
- R2: Tags start at 0 after reset and rise by one for each accepted request. An end-of-kernel sync (kind 3 with `req_eok` set) takes the current value of `req_seq` without advancing it. Kind codes: 0 load, 1 store, 2 atomic with return, 3 memory sync.
- R3: No more than QCAP loads and atomics are in flight at once, counted from dispatch to retirement. When the cap is reached and the head is a load or atomic, `dn_valid` stays low.
- R4: No more than QCAP stores are in flight at once, with the same stall behaviour as R3. Memory syncs are not counted against either cap.
- R5: A stalled head stays at the front with its tag unchanged, and no younger request overtakes it downstream.
- R6: Each dispatched request except an end-of-kernel sync takes a tracking slot that starts not done. An end-of-kernel sync takes no slot and never retires.
- R7: A response marks the slot whose tag equals `rsp_seq` as done. If no live slot carries that tag, `rsp_err` is high in the same cycle and no state changes.
- R8: `ret_valid` is raised only for the oldest live slot, and only once it is done. A younger slot that is done waits.
- R9: A load or atomic retires only while `wb_ready` and `bus_free` are both high. Stores and syncs retire regardless of those two inputs.
- R10: A retirement frees its slot and its class credit at the same clock edge, so a head that was stalled on that cap can be dispatched in the next cycle.
- R11: Synchronous active-high reset clears tags, pointers, counters and done flags. After reset `req_ready` is 1, `req_seq` is 0, and `dn_valid`, `ret_valid` and `rsp_err` are 0.
- R12: Requests retire in the order they were issued, whatever order their responses arrive in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered to the issue queue |
| req_kind | input | 2 | Request kind (0 load, 1 store, 2 atomic, 3 sync) |
| req_eok | input | 1 | Marks a sync as end-of-kernel |
| req_ready | output | 1 | Issue queue has room |
| req_seq | output | SEQ_W | Tag that the next accepted request receives |
| dn_valid | output | 1 | Queue head offered downstream |
| dn_ready | input | 1 | Memory system takes the head |
| dn_kind | output | 2 | Kind of the head |
| dn_seq | output | SEQ_W | Tag of the head |
| rsp_valid | input | 1 | Completion response present |
| rsp_seq | input | SEQ_W | Tag of the completed request |
| rsp_err | output | 1 | Response tag matches no live slot |
| wb_ready | input | 1 | Register-file write port can accept a writeback |
| bus_free | input | 1 | Return bus is idle |
| ret_valid | output | 1 | Oldest slot retires at this edge |
| ret_kind | output | 2 | Kind of the retiring request |
| ret_seq | output | SEQ_W | Tag of the retiring request |

## Verification
A request accepted at one edge shows up as the head on `dn_valid`/`dn_seq` right after that edge. The bench drives inputs just after the falling edge and samples the combinational outputs one time unit later, in the same half cycle. A dispatch at edge N lets a response count at edge N+1. The slot's `ret_valid` can then rise only in the cycle after the response edge, and the bench looks for it in that cycle and no sooner. A freed credit shows up in `dn_valid` in the cycle right after the retirement edge. `rsp_err` is combinational on the response inputs, so it is checked in the same cycle the bad tag is driven.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

   typedef enum logic [1:0] {
      K_LOAD   = 2'd0,
      K_STORE  = 2'd1,
      K_ATOMIC = 2'd2,
      K_SYNC   = 2'd3
   } kind_e;

   localparam int N_CLS  = 2;
   localparam int CLS_LD = 0;
   localparam int CLS_ST = 1;

   // loads and returning atomics share the read credit pool
   function automatic logic uses_ld_credit(kind_e k);
      return (k == K_LOAD) || (k == K_ATOMIC);
   endfunction

   function automatic logic uses_st_credit(kind_e k);
      return (k == K_STORE);
   endfunction

   // results that must be written into the register file
   function automatic logic writes_regs(kind_e k);
      return (k == K_LOAD) || (k == K_ATOMIC);
   endfunction

   function automatic logic [N_CLS-1:0] credit_mask(kind_e k);
      logic [N_CLS-1:0] m;
      m = '0;
      m[CLS_LD] = uses_ld_credit(k);
      m[CLS_ST] = uses_st_credit(k);
      return m;
   endfunction

endpackage

// File: rtl/mrb_issue_q.sv
module mrb_issue_q #(
   parameter int DEPTH = 4,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         full,
   output logic         empty,
   output logic [W-1:0] head_data
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PTR_W = IDX_W + 1;

   initial begin : chk_params
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "issue queue depth must be a power of two of at least 2");
      assert (W >= 1) else $fatal(1, "issue queue payload width must be positive");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [IDX_W-1:0] wr_idx, rd_idx;

   assign wr_idx = wr_ptr[IDX_W-1:0];
   assign rd_idx = rd_ptr[IDX_W-1:0];

   assign empty     = (wr_ptr == rd_ptr);
   assign full      = (wr_idx == rd_idx) && (wr_ptr[IDX_W] != rd_ptr[IDX_W]);
   assign head_data = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_idx] <= push_data;
   end

   AST_IQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);                                                // R1
   AST_IQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);                                                // R5

endmodule

// File: rtl/mrb_inflight.sv
module mrb_inflight #(
   parameter int CAP = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic inc,
   input  logic dec,
   output logic room
);
   localparam int CW = $clog2(CAP + 1);

   initial begin : chk_params
      assert (CAP >= 1) else $fatal(1, "in-flight cap must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign room = (cnt < CW'(CAP));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   AST_CNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(CAP));                                               // R3, R4
   AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      dec |-> (cnt != '0));                                           // R10

endmodule

// File: rtl/mrb_order_buf.sv
module mrb_order_buf #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 8,
   parameter int KW    = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             alloc,
   input  logic [SEQ_W-1:0] alloc_seq,
   input  logic [KW-1:0]    alloc_kind,
   input  logic             mark,
   input  logic [SEQ_W-1:0] mark_seq,
   output logic             mark_hit,
   input  logic             pop,
   output logic             head_vld,
   output logic             head_done,
   output logic [SEQ_W-1:0] head_seq,
   output logic [KW-1:0]    head_kind,
   output logic             full
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PTR_W = IDX_W + 1;

   initial begin : chk_params
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "ordered buffer depth must be a power of two of at least 2");
      assert (SEQ_W > IDX_W) else $fatal(1, "tag must be wider than the slot index");
   end

   logic             ent_vld  [DEPTH];
   logic             ent_done [DEPTH];
   logic [SEQ_W-1:0] ent_seq  [DEPTH];
   logic [KW-1:0]    ent_kind [DEPTH];

   logic [PTR_W-1:0] hd_ptr, tl_ptr;
   logic [IDX_W-1:0] hd_idx, tl_idx, mk_idx;

   assign hd_idx = hd_ptr[IDX_W-1:0];
   assign tl_idx = tl_ptr[IDX_W-1:0];
   assign mk_idx = mark_seq[IDX_W-1:0];

   assign full      = (hd_idx == tl_idx) && (hd_ptr[IDX_W] != tl_ptr[IDX_W]);
   assign head_vld  = ent_vld[hd_idx];
   assign head_done = ent_done[hd_idx];
   assign head_seq  = ent_seq[hd_idx];
   assign head_kind = ent_kind[hd_idx];

   // a response hits only a live slot whose stored full tag matches
   assign mark_hit = mark && ent_vld[mk_idx] && (ent_seq[mk_idx] == mark_seq);

   always_ff @(posedge clk) begin
      if (rst) begin
         hd_ptr <= '0;
         tl_ptr <= '0;
      end else begin
         if (alloc) tl_ptr <= tl_ptr + PTR_W'(1);
         if (pop)   hd_ptr <= hd_ptr + PTR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (rst) begin
            ent_vld[i]  <= 1'b0;
            ent_done[i] <= 1'b0;
         end else begin
            if (alloc && tl_idx == IDX_W'(i)) begin
               ent_vld[i]  <= 1'b1;
               ent_done[i] <= 1'b0;
            end else if (mark_hit && mk_idx == IDX_W'(i)) begin
               ent_done[i] <= 1'b1;
            end
            if (pop && hd_idx == IDX_W'(i)) ent_vld[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc && tl_idx == IDX_W'(i)) begin
            ent_seq[i]  <= alloc_seq;
            ent_kind[i] <= alloc_kind;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      alloc |-> !full);                                               // R6
   AST_ALLOC_SLOT: assert property (@(posedge clk) disable iff (rst)
      alloc |-> (alloc_seq[IDX_W-1:0] == tl_idx));                    // R2
   AST_POP_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
      pop |-> (head_vld && head_done));                               // R8

endmodule

// File: rtl/mem_retire_buf.sv
module mem_retire_buf
   import mrb_pkg::*;
#(
   parameter int SEQ_W    = 8,
   parameter int IQ_DEPTH = 4,
   parameter int OB_DEPTH = 8,
   parameter int QCAP     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic             req_eok,
   output logic             req_ready,
   output logic [SEQ_W-1:0] req_seq,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [1:0]       dn_kind,
   output logic [SEQ_W-1:0] dn_seq,
   input  logic             rsp_valid,
   input  logic [SEQ_W-1:0] rsp_seq,
   output logic             rsp_err,
   input  logic             wb_ready,
   input  logic             bus_free,
   output logic             ret_valid,
   output logic [1:0]       ret_kind,
   output logic [SEQ_W-1:0] ret_seq
);
   localparam int KW   = 2;
   localparam int IQ_W = KW + 1 + SEQ_W;

   initial begin : chk_params
      assert (SEQ_W >= 2 && SEQ_W <= 30) else $fatal(1, "tag width out of range");
      assert (OB_DEPTH <= (1 << SEQ_W)) else $fatal(1, "buffer deeper than tag space");
      assert (QCAP >= 1) else $fatal(1, "cap must be at least 1");
   end

   // ---------------- tagging and issue queue ----------------
   logic             iq_push, iq_pop, iq_full, iq_empty;
   logic [IQ_W-1:0]  iq_head;
   logic [SEQ_W-1:0] seq_q;
   kind_e            in_kind;
   logic             in_eok_sync;

   assign in_kind     = kind_e'(req_kind);
   assign in_eok_sync = (in_kind == K_SYNC) && req_eok;
   assign req_ready   = !iq_full;
   assign req_seq     = seq_q;
   assign iq_push     = req_valid && !iq_full;

   always_ff @(posedge clk) begin
      if (rst)                         seq_q <= '0;
      else if (iq_push && !in_eok_sync) seq_q <= seq_q + SEQ_W'(1);
   end

   mrb_issue_q #(.DEPTH(IQ_DEPTH), .W(IQ_W)) u_iq (
      .clk       (clk),
      .rst       (rst),
      .push      (iq_push),
      .push_data ({req_kind, req_eok, seq_q}),
      .pop       (iq_pop),
      .full      (iq_full),
      .empty     (iq_empty),
      .head_data (iq_head)
   );

   // ---------------- dispatch gate ----------------
   kind_e            h_kind;
   logic             h_eok;
   logic [SEQ_W-1:0] h_seq;
   logic             h_eok_sync, h_takes_slot, cap_ok, dn_fire;
   logic [N_CLS-1:0] h_use, r_use, cr_inc, cr_dec, cr_room;
   logic             ob_full;

   assign h_kind       = kind_e'(iq_head[IQ_W-1 -: KW]);
   assign h_eok        = iq_head[SEQ_W];
   assign h_seq        = iq_head[SEQ_W-1:0];
   assign h_eok_sync   = (h_kind == K_SYNC) && h_eok;
   assign h_takes_slot = !h_eok_sync;
   assign h_use        = credit_mask(h_kind);
   assign cap_ok       = ((h_use & ~cr_room) == '0);

   assign dn_valid = !iq_empty && cap_ok && (!h_takes_slot || !ob_full);
   assign dn_kind  = h_kind;
   assign dn_seq   = h_seq;
   assign dn_fire  = dn_valid && dn_ready;
   assign iq_pop   = dn_fire;

   // ---------------- per-class credit counters ----------------
   generate
      for (genvar c = 0; c < N_CLS; c++) begin : g_cls
         assign cr_inc[c] = dn_fire && h_use[c];
         assign cr_dec[c] = ret_valid && r_use[c];
         mrb_inflight #(.CAP(QCAP)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc  (cr_inc[c]),
            .dec  (cr_dec[c]),
            .room (cr_room[c])
         );
      end
   endgenerate

   // ---------------- ordered tracking buffer ----------------
   logic             ob_hit, ob_hd_vld, ob_hd_done;
   logic [SEQ_W-1:0] ob_hd_seq;
   logic [KW-1:0]    ob_hd_kind;
   kind_e            r_kind;

   mrb_order_buf #(.DEPTH(OB_DEPTH), .SEQ_W(SEQ_W), .KW(KW)) u_ob (
      .clk        (clk),
      .rst        (rst),
      .alloc      (dn_fire && h_takes_slot),
      .alloc_seq  (h_seq),
      .alloc_kind (KW'(h_kind)),
      .mark       (rsp_valid),
      .mark_seq   (rsp_seq),
      .mark_hit   (ob_hit),
      .pop        (ret_valid),
      .head_vld   (ob_hd_vld),
      .head_done  (ob_hd_done),
      .head_seq   (ob_hd_seq),
      .head_kind  (ob_hd_kind),
      .full       (ob_full)
   );

   assign rsp_err = rsp_valid && !ob_hit;

   // ---------------- retirement ----------------
   assign r_kind    = kind_e'(ob_hd_kind);
   assign r_use     = credit_mask(r_kind);
   assign ret_valid = ob_hd_vld && ob_hd_done &&
                      (!writes_regs(r_kind) || (wb_ready && bus_free));
   assign ret_kind  = ob_hd_kind;
   assign ret_seq   = ob_hd_seq;

   // ---------------- checks ----------------
   logic             seen_ret;
   logic [SEQ_W-1:0] last_ret;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_ret <= 1'b0;
         last_ret <= '0;
      end else if (ret_valid) begin
         seen_ret <= 1'b1;
         last_ret <= ret_seq;
      end
   end

   AST_WB_GATE: assert property (@(posedge clk) disable iff (rst)
      (ret_valid && (ret_kind == 2'd0 || ret_kind == 2'd2)) |-> (wb_ready && bus_free)); // R9
   AST_RET_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
      (ret_valid && seen_ret) |-> (ret_seq == last_ret + SEQ_W'(1)));  // R12
   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!iq_empty && !dn_fire) |=> (dn_seq == $past(dn_seq)));          // R5

endmodule

// File: tb/tb_mem_retire_buf.sv
module tb_mem_retire_buf;
   localparam int CLK_P = 10;
   localparam int SW    = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic          req_eok = 1'b0;
   logic          req_ready;
   logic [SW-1:0] req_seq;
   logic          dn_valid;
   logic          dn_ready = 1'b0;
   logic [1:0]    dn_kind;
   logic [SW-1:0] dn_seq;
   logic          rsp_valid = 1'b0;
   logic [SW-1:0] rsp_seq = '0;
   logic          rsp_err;
   logic          wb_ready = 1'b0;
   logic          bus_free = 1'b0;
   logic          ret_valid;
   logic [1:0]    ret_kind;
   logic [SW-1:0] ret_seq;

   always #(CLK_P/2) clk = ~clk;

   mem_retire_buf #(.SEQ_W(SW), .IQ_DEPTH(4), .OB_DEPTH(8), .QCAP(2)) dut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_kind(req_kind), .req_eok(req_eok),
      .req_ready(req_ready), .req_seq(req_seq),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_seq(dn_seq),
      .rsp_valid(rsp_valid), .rsp_seq(rsp_seq), .rsp_err(rsp_err),
      .wb_ready(wb_ready), .bus_free(bus_free),
      .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_seq(ret_seq)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done_f = 1'b0;

   task automatic chk(input int got, input int exp, input string tag);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drv(input logic rq, input logic [1:0] kd, input logic eo,
                      input logic dr, input logic rv, input logic [SW-1:0] rs,
                      input logic wb, input logic bf);
      req_valid = rq; req_kind = kd; req_eok = eo; dn_ready = dr;
      rsp_valid = rv; rsp_seq = rs; wb_ready = wb; bus_free = bf;
      #1;
   endtask

   task automatic do_reset();
      drv(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   // one cycle per row: inputs, then expected outputs seen before the next edge
   typedef struct packed {
      logic rq; logic [1:0] kd; logic eo; logic dr;
      logic rv; logic [7:0] rs; logic wb; logic bf;
      logic [7:0] e_rqs; logic e_dv; logic [7:0] e_ds;
      logic e_rv; logic [7:0] e_rs; logic e_err;
   } vec_t;
   localparam int NV = 15;

   function automatic vec_t vec_at(input int i);
      case (i)
         0:  return '{1'b1,2'd0,1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 8'd0, 1'b0,8'd0, 1'b0,8'd0, 1'b0};
         1:  return '{1'b1,2'd1,1'b0,1'b1, 1'b0,8'd0, 1'b0,1'b0, 8'd1, 1'b1,8'd0, 1'b0,8'd0, 1'b0};
         2:  return '{1'b1,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b0,1'b0, 8'd2, 1'b1,8'd1, 1'b0,8'd0, 1'b0};
         3:  return '{1'b0,2'd0,1'b0,1'b1, 1'b1,8'd1, 1'b0,1'b0, 8'd3, 1'b1,8'd2, 1'b0,8'd0, 1'b0};
         4:  return '{1'b1,2'd0,1'b0,1'b1, 1'b1,8'd0, 1'b0,1'b1, 8'd3, 1'b0,8'd0, 1'b0,8'd0, 1'b0};
         5:  return '{1'b0,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b0,1'b1, 8'd4, 1'b0,8'd0, 1'b0,8'd0, 1'b0};
         6:  return '{1'b0,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b1,1'b1, 8'd4, 1'b0,8'd0, 1'b1,8'd0, 1'b0};
         7:  return '{1'b0,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b0,1'b0, 8'd4, 1'b1,8'd3, 1'b1,8'd1, 1'b0};
         8:  return '{1'b0,2'd0,1'b0,1'b1, 1'b1,8'd3, 1'b0,1'b0, 8'd4, 1'b0,8'd0, 1'b0,8'd0, 1'b0};
         9:  return '{1'b0,2'd0,1'b0,1'b1, 1'b1,8'd9, 1'b0,1'b0, 8'd4, 1'b0,8'd0, 1'b0,8'd0, 1'b1};
         10: return '{1'b0,2'd0,1'b0,1'b1, 1'b1,8'd2, 1'b1,1'b1, 8'd4, 1'b0,8'd0, 1'b0,8'd0, 1'b0};
         11: return '{1'b0,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b1,1'b1, 8'd4, 1'b0,8'd0, 1'b1,8'd2, 1'b0};
         12: return '{1'b0,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b1,1'b0, 8'd4, 1'b0,8'd0, 1'b0,8'd0, 1'b0};
         13: return '{1'b0,2'd0,1'b0,1'b1, 1'b0,8'd0, 1'b1,1'b1, 8'd4, 1'b0,8'd0, 1'b1,8'd3, 1'b0};
         default: return '{1'b0,2'd0,1'b0,1'b1, 1'b1,8'd3, 1'b1,1'b1, 8'd4, 1'b0,8'd0, 1'b0,8'd0, 1'b1};
      endcase
   endfunction

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done_f) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] lfsr;
      int          perm [4];
      int          exp_ret;
      int          n_ret;
      lfsr = 16'hACE1;

      // ---- R11 reset state ----
      do_reset();
      chk(int'(req_ready), 1, "R11 req_ready");
      chk(int'(req_seq),   0, "R11 req_seq");
      chk(int'(dn_valid),  0, "R11 dn_valid");
      chk(int'(ret_valid), 0, "R11 ret_valid");
      chk(int'(rsp_err),   0, "R11 rsp_err");

      // ---- table: R2 R3 R7 R8 R9 R10 ----
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = vec_at(i);
         drv(v.rq, v.kd, v.eo, v.dr, v.rv, v.rs, v.wb, v.bf);
         chk(int'(req_seq), int'(v.e_rqs), "R2 table req_seq");
         chk(int'(dn_valid), int'(v.e_dv), "R3 table dn_valid");
         if (v.e_dv) chk(int'(dn_seq), int'(v.e_ds), "R5 table dn_seq");
         chk(int'(ret_valid), int'(v.e_rv), "R8/R9 table ret_valid");
         if (v.e_rv) chk(int'(ret_seq), int'(v.e_rs), "R8 table ret_seq");
         chk(int'(rsp_err), int'(v.e_err), "R7 table rsp_err");
         tick();
      end

      // ---- R1 queue full, R3 load cap, R5 no bypass, R8, R10 ----
      do_reset();
      for (int i = 0; i < 4; i++) begin
         drv(1'b1, (i == 3) ? 2'd1 : 2'd0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
         chk(int'(req_ready), 1, "R1 room before full");
         tick();
      end
      drv(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
      chk(int'(req_ready), 0, "R1 ready low when full");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1);
      chk(int'(req_seq), 4, "R1 dropped request took no tag");
      chk(int'(dn_seq), 0, "R1 fifo order head");
      tick();
      chk(int'(dn_seq), 1, "R1 fifo order second");
      tick();
      chk(int'(dn_valid), 0, "R3 load cap stalls");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd1, 1'b1, 1'b1);
      chk(int'(dn_valid), 0, "R5 store behind stalled load held");
      chk(int'(dn_seq), 2, "R5 head tag unchanged");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b1, 1'b1);
      chk(int'(ret_valid), 0, "R8 younger done waits");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1);
      chk(int'(ret_valid), 1, "R8 oldest retires");
      chk(int'(ret_seq), 0, "R8 oldest tag");
      chk(int'(dn_valid), 0, "R3 cap still full");
      tick();
      chk(int'(ret_seq), 1, "R8 next oldest");
      chk(int'(dn_valid), 1, "R10 credit freed next cycle");
      chk(int'(dn_seq), 2, "R10 waiting load dispatched");
      tick();
      chk(int'(dn_valid), 1, "R5 store follows");
      chk(int'(dn_seq), 3, "R5 store tag");
      tick();

      // ---- R2 R6 R9 R4 end-of-kernel sync, sync retirement, caps ----
      do_reset();
      drv(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk(int'(req_seq), 0, "R2 eok sync tag");
      tick();
      drv(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk(int'(req_seq), 0, "R2 eok sync consumed no tag");
      tick();
      drv(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk(int'(req_seq), 1, "R2 sync advanced tag");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
      chk(int'(dn_kind), 3, "R6 eok sync offered");
      chk(int'(dn_seq), 0, "R6 eok sync tag");
      tick();
      chk(int'(dn_seq), 0, "R6 plain sync tag");
      chk(int'(ret_valid), 0, "R6 eok sync not retired");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0);
      chk(int'(dn_seq), 1, "R6 store tag");
      chk(int'(rsp_err), 0, "R7 sync slot present");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, 1'b0);
      chk(int'(ret_valid), 1, "R9 sync ignores wb/bus");
      chk(int'(ret_kind), 3, "R9 retiring kind");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'd2, 1'b0, 1'b0);
      chk(int'(ret_valid), 1, "R9 store ignores wb/bus");
      chk(int'(ret_seq), 1, "R9 store tag");
      chk(int'(rsp_err), 1, "R7 unknown tag flagged");
      tick();
      drv(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk(int'(ret_valid), 0, "R6 nothing left to retire");
      for (int i = 0; i < 3; i++) begin
         drv(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
         tick();
      end
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         chk(int'(dn_valid), 1, "R4 syncs use no cap");
         chk(int'(dn_seq), 2 + i, "R4 sync tag");
         tick();
      end
      for (int i = 0; i < 3; i++) begin
         drv(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
         tick();
      end
      drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
      chk(int'(dn_valid), 1, "R4 first store");
      tick();
      chk(int'(dn_valid), 1, "R4 second store");
      tick();
      chk(int'(dn_valid), 0, "R4 store cap stalls");
      chk(int'(dn_seq), 7, "R4 stalled store tag");
      tick();

      // ---- R12 random response order ----
      do_reset();
      exp_ret = 0;
      n_ret   = 0;
      for (int b = 0; b < 6; b++) begin
         for (int i = 0; i < 4; i++) begin
            drv(1'b1, (i == 0) ? 2'd0 : (i == 2) ? 2'd2 : 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
            tick();
         end
         for (int i = 0; i < 4; i++) begin
            drv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1);
            chk(int'(dn_seq), 4*b + i, "R12 dispatch order");
            tick();
         end
         for (int i = 0; i < 4; i++) perm[i] = i;
         for (int i = 3; i > 0; i--) begin
            int j, t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            j = int'(lfsr) % (i + 1);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
         end
         for (int i = 0; i < 9; i++) begin
            if (i < 4) drv(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, SW'(4*b + perm[i]), 1'b1, 1'b1);
            else       drv(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
            if (ret_valid) begin
               chk(int'(ret_seq), exp_ret, "R12 retire order");
               exp_ret++;
               n_ret++;
            end
            tick();
         end
         chk(n_ret, 4*(b + 1), "R12 all retired");
      end

      done_f = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule